// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Tracker

This block sits beside the command scheduler of an SDRAM controller. It tracks timing for each bank. It watches each READ or WRITE that is issued, the auto-precharge flag carried by that command, the burst length configured at the time of issue, and any BURST TERMINATE commands. From these it keeps one ready flag per bank. The scheduler may send a new READ or WRITE to a bank only while that bank's flag is high.

A burst occupies its bank until its last beat. If the command asked for auto-precharge and the burst is fixed-length, the bank then stays busy for an implicit precharge of `TRP` cycles. For a write, that precharge starts one cycle later, which models write recovery. Full-page bursts run until they are terminated and never precharge by themselves. A terminate always cuts the most recently accepted READ or WRITE, whichever bank that was. A READ or WRITE that reaches a busy bank is refused and latches a protocol-error flag.

Top module: `apre_bank_tracker`

## Requirements
- R1: After reset, every bit of `bank_ready` is 1, `all_idle` is 1 and `proto_err` is 0.
- R2: Command encoding on `cmd` is 00 NOP, 01 READ, 10 WRITE and 11 terminate. `burst_cfg` selects the burst length as 000→1, 001→2, 010→4, 011→8 and 111→full page; 100, 101 and 110 act as length 1. Without auto-precharge, a fixed-length burst of length BL accepted at edge e0 makes the bank not ready after e0, and ready again after edge e0+BL.
- R3: A READ with `ap_en` set and fixed length BL, accepted at e0, keeps the bank busy until edge e0+BL+TRP.
- R4: A WRITE with `ap_en` set and fixed length BL, accepted at e0, keeps the bank busy until edge e0+BL+1+TRP. This is one cycle of write recovery before the precharge.
- R5: Auto-precharge applies only to the command that carries it. A later command to the same bank without `ap_en` gets plain burst timing.
- R6: A full-page burst keeps its bank busy for as long as no terminate arrives. On the terminate edge the bank becomes ready at once, with no precharge, even if `ap_en` was set.
- R7: A terminate ends only the burst of the most recently accepted READ or WRITE. Bursts in other banks continue. A terminate that arrives after that burst has already ended has no effect.
- R8: A terminate on a fixed-length burst that carries auto-precharge ends the burst at the terminate edge and then runs the precharge. For a read, the bank is ready TRP edges later; for a write, TRP+1 edges later.
- R9: A READ or WRITE to a bank whose ready flag is low sets `proto_err`, which stays set until reset. The refused command changes no bank's timing.
- R10: `all_idle` is 1 exactly when every bank is ready.
- R11: The burst length and the full-page choice are taken from `burst_cfg` at the accepting edge. Changing `burst_cfg` during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code: 00 NOP, 01 READ, 10 WRITE, 11 terminate |
| bank | input | 2 | Target bank of a READ or WRITE; ignored for other codes |
| ap_en | input | 1 | Auto-precharge request carried with a READ or WRITE |
| burst_cfg | input | 3 | Burst length selection sampled with each accepted command |
| bank_ready | output | 4 | One flag per bank; 1 means the bank may take a new command |
| all_idle | output | 1 | 1 when every bank is ready |
| proto_err | output | 1 | Sticky flag set by a command sent to a busy bank |

## Verification
The assertions take it that `cmd`, `bank` and `burst_cfg` hold known values at every rising edge after reset. They also take it that `bank` names one of the configured banks. The bench drives every input on the falling edge from tasks. It therefore holds them steady across each rising edge, and it uses only bank numbers 0 to 3. The bench sends commands to busy banks only in the scenario that targets the error flag. Every other scenario waits for the ready flag first, so that each measured busy window belongs to one command alone.

// File: rtl/apre_pkg.sv
package apre_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_TERM  = 2'b11
  } apre_cmd_e;

  localparam int BEAT_W = 4;

  // Number of data beats for a fixed-length setting; reserved codes act as one beat.
  function automatic logic [BEAT_W-1:0] beats_of(input logic [2:0] cfg);
    case (cfg)
      3'b001:  return BEAT_W'(2);
      3'b010:  return BEAT_W'(4);
      3'b011:  return BEAT_W'(8);
      default: return BEAT_W'(1);
    endcase
  endfunction

  function automatic logic is_page(input logic [2:0] cfg);
    return cfg == 3'b111;
  endfunction

endpackage

// File: rtl/apre_cmd_decode.sv
module apre_cmd_decode
  import apre_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] ready_vec,
  output logic [NUM_BANKS-1:0] start_vec,
  output logic                 start_write,
  output logic [NUM_BANKS-1:0] term_vec,
  output logic                 err_flag
);

  apre_cmd_e   code;
  logic        is_rw;
  logic        accept;
  logic        reject;
  logic [BANK_W-1:0] last_bank;
  logic        last_valid;

  assign code        = apre_cmd_e'(cmd);
  assign is_rw       = (code == CMD_READ) || (code == CMD_WRITE);
  assign accept      = is_rw && ready_vec[bank];
  assign reject      = is_rw && !ready_vec[bank];
  assign start_write = (code == CMD_WRITE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_route
    assign start_vec[b] = accept && (bank == BANK_W'(b));
    assign term_vec[b]  = (code == CMD_TERM) && last_valid && (last_bank == BANK_W'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_bank  <= '0;
      last_valid <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (accept) begin
        last_bank  <= bank;
        last_valid <= 1'b1;
      end
      if (reject) err_flag <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_flag); // R9
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec)); // R9
  AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term_vec)); // R7

endmodule

// File: rtl/apre_bank_slot.sv
module apre_bank_slot
  import apre_pkg::*;
#(
  parameter int TRP = 3,
  localparam int PRE_W = $clog2(TRP + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  input  logic       ap,
  input  logic [2:0] cfg,
  input  logic       term,
  output logic       ready
);

  logic              active;
  logic [BEAT_W-1:0] beats_left;
  logic              page_q;
  logic              ap_q;
  logic              wr_q;
  logic              rec_q;
  logic [PRE_W-1:0]  pre_q;
  logic              burst_end;
  logic              pre_now;
  logic              rec_now;

  // Named events for the checks below.
  assign burst_end = active && (term || (!page_q && beats_left == BEAT_W'(1)));
  assign pre_now   = burst_end && ap_q && !page_q && !wr_q;
  assign rec_now   = burst_end && ap_q && !page_q && wr_q;
  assign ready     = !active && !rec_q && (pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      beats_left <= '0;
      page_q     <= 1'b0;
      ap_q       <= 1'b0;
      wr_q       <= 1'b0;
      rec_q      <= 1'b0;
      pre_q      <= '0;
    end else begin
      if (start) begin
        active     <= 1'b1;
        beats_left <= beats_of(cfg);
        page_q     <= is_page(cfg);
        ap_q       <= ap;
        wr_q       <= start_wr;
      end else if (burst_end) begin
        active     <= 1'b0;
        beats_left <= '0;
      end else if (active && !page_q) begin
        beats_left <= beats_left - 1'b1;
      end
      rec_q <= rec_now;
      if (pre_now || rec_q) pre_q <= PRE_W'(TRP);
      else if (pre_q != '0) pre_q <= pre_q - 1'b1;
    end
  end

  AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready); // R9
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready); // R2
  AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q != '0) |=> (pre_q == $past(pre_q) - 1'b1)); // R3
  AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q |=> (pre_q == PRE_W'(TRP))); // R4
  AST_PAGE_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && page_q) |=> (ready && pre_q == '0)); // R6

endmodule

// File: rtl/apre_bank_tracker.sv
module apre_bank_tracker
  import apre_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP = 3,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 ap_en,
  input  logic [2:0]           burst_cfg,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic                 all_idle,
  output logic                 proto_err
);

  logic [NUM_BANKS-1:0] start_vec;
  logic [NUM_BANKS-1:0] term_vec;
  logic                 start_write;

  apre_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .bank        (bank),
    .ready_vec   (bank_ready),
    .start_vec   (start_vec),
    .start_write (start_write),
    .term_vec    (term_vec),
    .err_flag    (proto_err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    apre_bank_slot #(.TRP(TRP)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_vec[b]),
      .start_wr (start_write),
      .ap       (ap_en),
      .cfg      (burst_cfg),
      .term     (term_vec[b]),
      .ready    (bank_ready[b])
    );
  end

  assign all_idle = &bank_ready;

  AST_IDLE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_idle) |-> ($past(cmd) == CMD_READ || $past(cmd) == CMD_WRITE)); // R10

endmodule

// File: tb/apre_bank_tracker_test.sv
module apre_bank_tracker_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [1:0] bank = 2'b00;
  logic       ap_en = 1'b0;
  logic [2:0] burst_cfg = 3'b000;
  logic [3:0] bank_ready;
  logic       all_idle;
  logic       proto_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  localparam int TRP = 3;

  apre_bank_tracker #(.NUM_BANKS(4), .TRP(TRP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .ap_en(ap_en),
    .burst_cfg(burst_cfg), .bank_ready(bank_ready), .all_idle(all_idle),
    .proto_err(proto_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd = 2'b00; ap_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after the command's rising edge.
  task automatic issue(input logic [1:0] c, input logic [1:0] b, input logic ap,
                       input logic [2:0] cfg);
    cmd = c; bank = b; ap_en = ap; burst_cfg = cfg;
    @(negedge clk);
    cmd = 2'b00; ap_en = 1'b0;
  endtask

  task automatic measure(input int b, output int n);
    n = 0;
    while (!bank_ready[b] && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", int'(bank_ready), 15, "ready after reset");
    check("R1", int'(all_idle), 1, "all_idle after reset");
    check("R1", int'(proto_err), 0, "error after reset");
  endtask

  task automatic t_fixed();
    int n;
    issue(2'b01, 2'd1, 1'b0, 3'b000); measure(1, n); check("R2", n, 1, "read BL1");
    issue(2'b01, 2'd1, 1'b0, 3'b001); measure(1, n); check("R2", n, 2, "read BL2");
    issue(2'b01, 2'd1, 1'b0, 3'b010); measure(1, n); check("R2", n, 4, "read BL4");
    issue(2'b01, 2'd1, 1'b0, 3'b011); measure(1, n); check("R2", n, 8, "read BL8");
    issue(2'b01, 2'd1, 1'b0, 3'b101); measure(1, n); check("R2", n, 1, "reserved code");
    issue(2'b10, 2'd2, 1'b0, 3'b010); measure(2, n); check("R2", n, 4, "write BL4");
  endtask

  task automatic t_read_ap();
    int n;
    issue(2'b01, 2'd0, 1'b1, 3'b010); measure(0, n); check("R3", n, 4 + TRP, "read BL4 ap");
    issue(2'b01, 2'd0, 1'b1, 3'b000); measure(0, n); check("R3", n, 1 + TRP, "read BL1 ap");
  endtask

  task automatic t_write_ap();
    int n;
    issue(2'b10, 2'd3, 1'b1, 3'b010); measure(3, n); check("R4", n, 4 + 1 + TRP, "write BL4 ap");
    issue(2'b10, 2'd3, 1'b1, 3'b001); measure(3, n); check("R4", n, 2 + 1 + TRP, "write BL2 ap");
  endtask

  task automatic t_nonpersist();
    int n;
    issue(2'b01, 2'd0, 1'b1, 3'b010); measure(0, n); check("R5", n, 4 + TRP, "first with ap");
    issue(2'b01, 2'd0, 1'b0, 3'b010); measure(0, n); check("R5", n, 4, "second without ap");
  endtask

  task automatic t_page();
    int n;
    issue(2'b01, 2'd2, 1'b1, 3'b111);
    repeat (20) @(negedge clk);
    check("R6", int'(bank_ready[2]), 0, "page burst still busy");
    issue(2'b11, 2'd0, 1'b0, 3'b111);
    check("R6", int'(bank_ready[2]), 1, "ready right after terminate");
    measure(2, n); check("R6", n, 0, "no precharge on page burst");
  endtask

  task automatic t_term_latest();
    int n;
    issue(2'b01, 2'd0, 1'b0, 3'b011);
    issue(2'b01, 2'd1, 1'b0, 3'b011);
    issue(2'b11, 2'd0, 1'b0, 3'b011);
    check("R7", int'(bank_ready[1]), 1, "latest burst cut");
    check("R7", int'(bank_ready[0]), 0, "older burst continues");
    measure(0, n); check("R7", n, 6, "older burst full length");
    issue(2'b11, 2'd0, 1'b0, 3'b011);
    check("R7", int'(bank_ready), 15, "late terminate no effect");
  endtask

  task automatic t_term_ap();
    int n;
    issue(2'b01, 2'd0, 1'b1, 3'b011);
    issue(2'b11, 2'd0, 1'b0, 3'b011);
    measure(0, n); check("R8", n, TRP, "read cut then precharge");
    issue(2'b10, 2'd1, 1'b1, 3'b011);
    issue(2'b11, 2'd0, 1'b0, 3'b011);
    measure(1, n); check("R8", n, TRP + 1, "write cut then recovery and precharge");
  endtask

  task automatic t_error();
    int n;
    check("R9", int'(proto_err), 0, "no error yet");
    issue(2'b01, 2'd0, 1'b1, 3'b010);
    issue(2'b10, 2'd0, 1'b0, 3'b000);
    check("R9", int'(proto_err), 1, "error on busy bank");
    measure(0, n); check("R9", n, 4 + TRP - 1, "refused command left timing alone");
    repeat (5) @(negedge clk);
    check("R9", int'(proto_err), 1, "error sticky");
    do_reset();
    check("R1", int'(proto_err), 0, "reset clears error");
  endtask

  task automatic t_all_idle();
    int n;
    issue(2'b01, 2'd1, 1'b0, 3'b010);
    check("R10", int'(all_idle), 0, "not idle during burst");
    check("R10", int'(bank_ready), 13, "only bank1 busy");
    measure(1, n);
    check("R10", int'(all_idle), 1, "idle after burst");
  endtask

  task automatic t_cfg_latch();
    int n;
    issue(2'b01, 2'd2, 1'b0, 3'b011);
    burst_cfg = 3'b000;
    measure(2, n); check("R11", n, 8, "length fixed at issue");
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_read_ap();
    t_write_ap();
    t_nonpersist();
    t_page();
    t_term_latest();
    t_term_ap();
    t_error();
    t_all_idle();
    t_cfg_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule